// File: doc/BRIEF.md
# SIR Transmit Byte Stuffer

This block sits in the transmit byte path of an infrared SIR framer, between the payload/CRC byte source and the flag inserter and serializer. It takes bytes over a valid/ready input. Each byte goes out over a valid/ready output. A byte that could be mistaken for a frame delimiter or for the escape code goes out as two bytes: the escape code, then the byte with bit 5 inverted. The three such values are the begin flag 0xC0, the end flag 0xC1 and the escape code 0x7D.

Each accepted byte is also handed, unmodified, to a CRC side port. The CRC engine therefore sees exactly what the source wrote, and escaping has no effect on it.

A one-cycle abort request makes the block close the frame early. When the request is seen, the output byte in flight completes. The block then sends the raw pair 0x7D, 0xC1 without escaping and returns to idle. No CRC and no closing flag follow the pair. Flag generation, CRC arithmetic and bit serialization are done elsewhere.

Top module: `sir_byte_stuffer`

## Requirements
- R1: A byte that is not 0xC0, 0xC1 or 0x7D appears once on the output, unchanged.
- R2: A byte equal to 0xC0, 0xC1 or 0x7D appears as 0x7D followed by the byte XOR 0x20, giving 0xE0, 0xE1 and 0x5D respectively.
- R3: crc_valid is high for exactly one cycle per accepted input byte, in the cycle after acceptance. crc_data then holds the byte as written, before any XOR.
- R4: While the escape code of an escaped pair is being presented, in_ready is low, whatever the level of out_ready.
- R5: Once out_valid is high, it stays high and out_data stays unchanged until a cycle with out_ready high.
- R6: A one-cycle pulse on abort_req makes the block emit 0x7D then 0xC1 after the byte currently presented is taken. The block then goes idle with out_valid low. in_ready is low from the pulse until the abort pair has started.
- R7: An abort overrides a pending escaped byte. If abort_req arrives while the escape code is presented, the inverted byte is dropped, and the output continues with 0x7D then 0xC1.
- R8: After reset, out_valid and crc_valid are low and in_ready is high.
- R9: Neighbours of the special values, such as 0x7C, 0x7E, 0xBF, 0xC2, 0x5D and 0xE0, are not escaped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Payload or CRC byte |
| in_ready | output | 1 | Input byte is accepted this cycle when in_valid is also high |
| abort_req | input | 1 | One-cycle request to close the frame with the abort pair |
| out_valid | output | 1 | Output byte presented |
| out_data | output | 8 | Stuffed output byte |
| out_ready | input | 1 | Downstream takes out_data this cycle |
| crc_valid | output | 1 | Strobe: one original byte on crc_data |
| crc_data | output | 8 | Original byte for the CRC engine |

## Verification
Several input patterns are used, and each separates a different fault:
- A plain byte run that includes the near-miss neighbours of the special values shows whether the escape decoder matches too widely or too narrowly.
- A run made only of the three special values shows whether the XOR mask is wrong, and whether the CRC tap is wrongly fed from the escaped byte.
- A mixed run under an irregular out_ready pattern shows whether the block loses, duplicates or reorders bytes under back-pressure.
- An abort pulse during a plain byte, and an abort pulse during the escape code with the output stalled, show whether the abort pair is emitted correctly and whether the pending inverted byte is correctly dropped.

// File: rtl/sir_stuff_pkg.sv
package sir_stuff_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ESC_CODE   = 8'h7D;
  localparam logic [BYTE_W-1:0] FLAG_OPEN  = 8'hC0;
  localparam logic [BYTE_W-1:0] FLAG_CLOSE = 8'hC1;
  localparam int FLIP_BIT = 5;
  localparam logic [BYTE_W-1:0] FLIP_MASK  = BYTE_W'(1) << FLIP_BIT;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ESC,
    ST_LAST,
    ST_AB1,
    ST_AB2
  } stuff_state_t;

  function automatic logic needs_escape(input logic [BYTE_W-1:0] b);
    return (b == FLAG_OPEN) || (b == FLAG_CLOSE) || (b == ESC_CODE);
  endfunction

  function automatic logic [BYTE_W-1:0] flip_byte(input logic [BYTE_W-1:0] b);
    return b ^ FLIP_MASK;
  endfunction
endpackage

// File: rtl/sir_crc_tap.sv
module sir_crc_tap
  import sir_stuff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] raw_byte,
  output logic              crc_valid,
  output logic [BYTE_W-1:0] crc_data
);
  // One strobe per accepted byte; the byte is the one the source wrote.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      crc_valid <= 1'b0;
      crc_data  <= '0;
    end else begin
      crc_valid <= take;
      if (take) crc_data <= raw_byte;
    end
  end
endmodule

// File: rtl/sir_stuff_ctrl.sv
module sir_stuff_ctrl
  import sir_stuff_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              abort_req,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  input  logic              out_ready,
  output logic              take,
  output logic              esc_phase,
  output logic              abort_phase
);
  stuff_state_t      st;
  logic [BYTE_W-1:0] held_byte;
  logic              abort_pend;
  logic              abort_hit;
  logic              slot_free;
  logic              abort_take;
  logic              in_abort;

  assign abort_hit  = abort_req | abort_pend;
  assign in_abort   = (st == ST_AB1) || (st == ST_AB2);
  assign slot_free  = (st == ST_IDLE) || out_ready;
  assign abort_take = abort_hit && !in_abort && slot_free;
  assign in_ready   = !abort_hit && ((st == ST_IDLE) || ((st == ST_LAST) && out_ready));
  assign take       = in_valid && in_ready;
  assign out_valid  = (st != ST_IDLE);
  assign esc_phase  = (st == ST_ESC);
  assign abort_phase = (st == ST_AB1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      out_data   <= '0;
      held_byte  <= '0;
      abort_pend <= 1'b0;
    end else begin
      abort_pend <= abort_hit && !abort_take;
      if (abort_take) begin
        st       <= ST_AB1;
        out_data <= ESC_CODE;
      end else if (take) begin
        if (needs_escape(in_data)) begin
          st        <= ST_ESC;
          out_data  <= ESC_CODE;
          held_byte <= flip_byte(in_data);
        end else begin
          st       <= ST_LAST;
          out_data <= in_data;
        end
      end else if (out_ready) begin
        case (st)
          ST_ESC: begin
            st       <= ST_LAST;
            out_data <= held_byte;
          end
          ST_AB1: begin
            st       <= ST_AB2;
            out_data <= FLAG_CLOSE;
          end
          ST_LAST, ST_AB2: st <= ST_IDLE;
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sir_byte_stuffer.sv
module sir_byte_stuffer
  import sir_stuff_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  output logic        in_ready,
  input  logic        abort_req,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready,
  output logic        crc_valid,
  output logic [7:0]  crc_data
);
  logic take;
  logic esc_phase;
  logic abort_phase;

  sir_stuff_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .abort_req  (abort_req),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .take       (take),
    .esc_phase  (esc_phase),
    .abort_phase(abort_phase)
  );

  sir_crc_tap tap_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .raw_byte (in_data),
    .crc_valid(crc_valid),
    .crc_data (crc_data)
  );
endmodule

// File: rtl/sir_byte_stuffer_chk.sv
module sir_byte_stuffer_chk
  import sir_stuff_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [7:0] in_data,
  input logic       in_ready,
  input logic       abort_req,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready,
  input logic       crc_valid,
  input logic [7:0] crc_data,
  input logic       esc_phase,
  input logic       abort_phase
);
  assert_plain_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !needs_escape(in_data)) |=> (out_valid && out_data == $past(in_data)));

  assert_escape_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && needs_escape(in_data)) |=> (out_valid && out_data == ESC_CODE));

  assert_crc_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (crc_valid && crc_data == $past(in_data)));

  assert_crc_only_on_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    crc_valid |-> $past(in_valid && in_ready));

  assert_escape_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    esc_phase |-> !in_ready);

  assert_output_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_abort_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> !in_ready);

  assert_abort_second_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_phase && out_ready) |=> (out_valid && out_data == FLAG_CLOSE));
endmodule

bind sir_byte_stuffer sir_byte_stuffer_chk chk_i (.*);

// File: tb/sir_byte_stuffer_tb.sv
module sir_byte_stuffer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready;
  logic       abort_req = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_ready = 1'b1;
  logic       crc_valid;
  logic [7:0] crc_data;

  int tests = 0;
  int fails = 0;
  int sink_mode = 0;   // 0 always ready, 1 irregular, 2 held low
  int pat = 0;
  int hold_errs = 0;
  logic prev_stall = 1'b0;
  logic [7:0] prev_byte = '0;
  logic [7:0] got_out[$];
  logic [7:0] got_crc[$];

  always #2 clk = ~clk;

  sir_byte_stuffer dut_i (.*);

  always @(negedge clk) begin
    pat <= pat + 1;
    out_ready <= (sink_mode == 0) ? 1'b1 :
                 (sink_mode == 1) ? ((pat % 3) != 1 && (pat % 7) != 4) : 1'b0;
  end

  // Monitor: sampled 1 ns after the falling edge, before the next rising edge.
  always begin
    @(negedge clk);
    #1;
    if (rst_n) begin
      if (prev_stall && (!out_valid || out_data != prev_byte)) hold_errs++;
      if (out_valid && out_ready) got_out.push_back(out_data);
      if (crc_valid) got_crc.push_back(crc_data);
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_data;
    end
  end

  initial begin
    #400000;
    fails++;
    tests++;
    $display("FAIL watchdog: run did not finish (got 0 expected done)");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic check(input string req, input logic ok, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void expand(input logic [7:0] b, ref logic [7:0] q[$]);
    if (b == 8'hC0 || b == 8'hC1 || b == 8'h7D) begin
      q.push_back(8'h7D);
      q.push_back(b ^ 8'h20);
    end else q.push_back(b);
  endfunction

  task automatic push(input logic [7:0] b);
    logic ok;
    in_valid = 1'b1;
    in_data  = b;
    do begin
      #1 ok = in_ready;
      @(negedge clk);
    end while (!ok);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    sink_mode = 0;
    repeat (20) @(negedge clk);
  endtask

  task automatic compare(input string req, input logic [7:0] exp[$],
                         input logic [7:0] raw[$]);
    int bad = 0;
    if (got_out.size() != exp.size()) bad++;
    else foreach (exp[i]) if (got_out[i] != exp[i]) bad++;
    check(req, bad == 0, "output stream mismatch count/len",
          got_out.size(), exp.size());
    bad = 0;
    if (got_crc.size() != raw.size()) bad++;
    else foreach (raw[i]) if (got_crc[i] != raw[i]) bad++;
    check("R3", bad == 0, "crc stream length", got_crc.size(), raw.size());
    got_out.delete();
    got_crc.delete();
  endtask

  task automatic t_reset_R8();
    #1;
    check("R8", out_valid == 1'b0, "out_valid after reset", out_valid, 0);
    check("R8", crc_valid == 1'b0, "crc_valid after reset", crc_valid, 0);
    check("R8", in_ready == 1'b1, "in_ready after reset", in_ready, 1);
  endtask

  task automatic t_plain_R1_R9();
    logic [7:0] raw[$] = '{8'h00, 8'h7C, 8'h7E, 8'hBF, 8'hC2, 8'h5D, 8'hE0, 8'hFF, 8'h20};
    logic [7:0] exp[$];
    foreach (raw[i]) begin
      expand(raw[i], exp);
      push(raw[i]);
    end
    drain();
    compare("R1 R9", exp, raw);
  endtask

  task automatic t_special_R2();
    logic [7:0] raw[$] = '{8'hC0, 8'hC1, 8'h7D, 8'h7D, 8'hC0};
    logic [7:0] exp[$];
    foreach (raw[i]) begin
      expand(raw[i], exp);
      push(raw[i]);
    end
    drain();
    check("R2", exp[1] == 8'hE0 && exp[3] == 8'hE1 && exp[5] == 8'h5D,
          "expected flips", exp[1], 8'hE0);
    compare("R2", exp, raw);
  endtask

  task automatic t_escape_block_R4();
    push(8'h7D);
    #1;
    check("R4", in_ready == 1'b0, "in_ready during escape code", in_ready, 0);
    check("R4", out_valid && out_data == 8'h7D, "escape code shown", out_data, 8'h7D);
    drain();
    got_out.delete();
    got_crc.delete();
  endtask

  task automatic t_backpressure_R5();
    logic [7:0] raw[$];
    logic [7:0] exp[$];
    hold_errs = 0;
    sink_mode = 1;
    for (int i = 0; i < 40; i++) begin
      logic [7:0] b = (i % 4 == 0) ? 8'hC0 + 8'(i % 3) : 8'(i * 37 + 5);
      if (i % 5 == 2) b = 8'h7D;
      raw.push_back(b);
      expand(b, exp);
      push(b);
    end
    drain();
    check("R5", hold_errs == 0, "stall hold violations", hold_errs, 0);
    compare("R5", exp, raw);
  endtask

  task automatic t_abort_R6();
    logic [7:0] raw[$] = '{8'h11};
    logic [7:0] exp[$] = '{8'h11, 8'h7D, 8'hC1};
    push(8'h11);
    abort_req = 1'b1;
    #1;
    check("R6", in_ready == 1'b0, "in_ready with abort", in_ready, 0);
    @(negedge clk);
    abort_req = 1'b0;
    drain();
    #1;
    check("R6", out_valid == 1'b0 && in_ready == 1'b1, "idle after abort", out_valid, 0);
    compare("R6", exp, raw);
  endtask

  task automatic t_abort_override_R7();
    logic [7:0] raw[$] = '{8'hC0};
    logic [7:0] exp[$] = '{8'h7D, 8'h7D, 8'hC1};
    sink_mode = 2;
    @(negedge clk);
    push(8'hC0);
    @(negedge clk);
    abort_req = 1'b1;
    @(negedge clk);
    abort_req = 1'b0;
    drain();
    #1;
    check("R7", out_valid == 1'b0, "idle after override", out_valid, 0);
    compare("R7", exp, raw);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_R8();
    @(negedge clk);
    t_plain_R1_R9();
    t_special_R2();
    t_escape_block_R4();
    t_backpressure_R5();
    t_abort_R6();
    t_abort_override_R7();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule